// File: doc/BRIEF.md
# ADC Channel-Group Trigger Sequencer

This block is the digital control side of an analog-to-digital converter that keeps several conversion slots, called channel groups. Each slot stores an input channel number, a differential-mode bit, an interrupt-enable bit and a conversion-complete flag. A slot also owns a result register. Software programs the slots through a simple register port. The block decides which slot drives the converter. It starts conversions on a software write or on a hardware trigger pulse. A stub converter signals completion a fixed number of cycles after each start, and the block then captures the sample.

Under hardware triggers the slots take turns. Each trigger pulse starts the next slot in a round-robin order, so one slot can be read back while another one converts. Writing the control word of the slot that is converting cancels that conversion. Writing the control word of any other slot leaves the running conversion untouched.

Register map, with G = NUM_GRP: slot g has its control word at address 2g and its result at address 2g+1. The mode register is at 2G. The status register is at 2G+1.

Top module: `adc_grp_sequencer`

## Requirements
- R1: After reset, conv_busy and irq are 0, and the control, mode and status registers all read back as 0.
- R2: With hardware triggering off (mode bit 0 = 0), a write to the slot 0 control word starts a conversion in the clock edge that takes the write. conv_busy is then high for exactly CONV_CYC cycles. At the completion edge, ana_sample is stored in the slot 0 result and the slot's complete flag (control bit CH_W+2) is set.
- R3: A control-word write never starts a conversion in either of two cases: the write goes to a slot other than 0 in software mode, or any slot is written while hardware triggering is on (mode bit 0 = 1).
- R4: In hardware mode, each rising edge of hw_trig seen while idle starts the slot at the rotation pointer, and the pointer then advances. The pointer counts 0, 1, …, NUM_GRP-1 and wraps to 0. A write to the mode register resets the pointer to 0.
- R5: A rising edge of hw_trig that arrives while a conversion is running is ignored. The active slot and the rotation pointer do not change.
- R6: Writing the control word of the slot that is converting aborts the conversion, and no complete flag is set. In software mode, a write to slot 0 while slot 0 is converting restarts the conversion with the new settings.
- R7: Writing the control word of a slot that is not converting does not change the timing, the channel or the completion of the running conversion.
- R8: irq is high exactly when at least one slot has both its complete flag and its interrupt-enable bit (control bit CH_W+1) set.
- R9: Reading a slot's result register clears that slot's complete flag and leaves the flags of the other slots unchanged.
- R10: With continuous mode on (mode bit 1 = 1), each completion immediately starts a new conversion. That conversion uses slot 0 in software mode, or the slot at the rotation pointer in hardware mode.
- R11: The status register reads back bit 0 = conversion active, and bits GW:1 = the index of the slot that was most recently started.
- R12: From the start edge onward, conv_chan and conv_diff hold the channel number (control bits CH_W-1:0) and the differential bit (control bit CH_W) of the started slot. When a start edge also writes that slot, the values written in that same edge are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after reg_rd |
| hw_trig | input | 1 | Hardware trigger, rising edge starts a conversion |
| ana_sample | input | RES_W | Sample value from the stub converter |
| conv_chan | output | CH_W | Channel presented to the converter |
| conv_diff | output | 1 | Differential mode presented to the converter |
| conv_busy | output | 1 | Conversion in progress |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume that reg_wr and reg_rd are never high in the same cycle, that every address lies inside the map, and that hw_trig is already synchronous to clk. The bench drives a single register access or a single trigger pulse per task, and each task occupies exactly one clock edge, so every access is a clean one-cycle strobe. Trigger pulses last one cycle and come after a low cycle, so each one counts as a single rising edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // mode register bit positions
  localparam int MODE_HW_BIT   = 0;
  localparam int MODE_CONT_BIT = 1;
  // status register
  localparam int STAT_BUSY_BIT = 0;

  typedef enum logic {TRIG_SW = 1'b0, TRIG_HW = 1'b1} trig_src_e;
endpackage

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
  parameter int CONV_CYC = 6,
  parameter int CH_W     = 5,
  parameter int GW       = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            abort,
  input  logic [GW-1:0]   start_grp,
  input  logic [CH_W-1:0] start_chan,
  input  logic            start_diff,
  output logic            busy,
  output logic            done,
  output logic [GW-1:0]   act_grp,
  output logic [CH_W-1:0] conv_chan,
  output logic            conv_diff
);
  localparam int CW = $clog2(CONV_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      act_grp   <= '0;
      conv_chan <= '0;
      conv_diff <= 1'b0;
    end else if (start) begin
      busy      <= 1'b1;
      cnt       <= CW'(CONV_CYC - 1);
      act_grp   <= start_grp;
      conv_chan <= start_chan;
      conv_diff <= start_diff;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  // R12
  start_chan_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (conv_chan == $past(start_chan)) && (conv_diff == $past(start_diff)));
endmodule

// File: rtl/adc_trig_sched.sv
module adc_trig_sched #(
  parameter int NUM_GRP = 4,
  parameter int GW      = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hw_en,
  input  logic          cont,
  input  logic          wr_ctrl,
  input  logic [GW-1:0] wr_grp,
  input  logic          wr_mode,
  input  logic          hw_trig,
  input  logic          busy,
  input  logic          done,
  input  logic [GW-1:0] act_grp,
  output logic          start,
  output logic [GW-1:0] start_grp,
  output logic          abort,
  output logic          fin
);
  import adc_seq_pkg::*;

  logic          trig_q;
  logic [GW-1:0] ptr;
  logic          trig_rise;
  trig_src_e     src;

  assign src       = hw_en ? TRIG_HW : TRIG_SW;
  assign trig_rise = hw_trig && !trig_q;
  assign abort     = busy && wr_ctrl && (wr_grp == act_grp);
  assign fin       = done && !abort;

  always_comb begin
    start     = 1'b0;
    start_grp = '0;
    if (src == TRIG_SW) begin
      start = (wr_ctrl && (wr_grp == '0)) || (fin && cont);
    end else begin
      start     = (trig_rise && !busy) || (fin && cont);
      start_grp = ptr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= 1'b0;
      ptr    <= '0;
    end else begin
      trig_q <= hw_trig;
      if (wr_mode)
        ptr <= '0;
      else if (start && src == TRIG_HW)
        ptr <= (ptr == GW'(NUM_GRP - 1)) ? '0 : ptr + 1'b1;
    end
  end

  // R3
  sw_grp0_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !hw_en) |-> (start_grp == '0));

  // R5
  busy_trig_ign_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && !abort) |=> $stable(act_grp));
endmodule

// File: rtl/adc_grp_bank.sv
module adc_grp_bank #(
  parameter int NUM_GRP = 4,
  parameter int CH_W    = 5,
  parameter int RES_W   = 12,
  parameter int DATA_W  = 16,
  parameter int AW      = 4,
  parameter int GW      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              set_en,
  input  logic [GW-1:0]     set_grp,
  input  logic [RES_W-1:0]  ana_sample,
  input  logic              busy,
  input  logic [GW-1:0]     act_grp,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              hw_en,
  output logic              cont,
  output logic [CH_W-1:0]   slot_chan [NUM_GRP],
  output logic              slot_diff [NUM_GRP]
);
  import adc_seq_pkg::*;

  localparam logic [AW-1:0] MODE_ADDR = AW'(2 * NUM_GRP);
  localparam logic [AW-1:0] STAT_ADDR = AW'(2 * NUM_GRP + 1);

  logic              slot_ie  [NUM_GRP];
  logic [NUM_GRP-1:0] flag_q, flag_d, ie_d;
  logic [RES_W-1:0]  res_mem  [NUM_GRP];

  logic          in_slots, is_ctrl, is_res;
  logic [GW-1:0] a_grp;

  assign in_slots = reg_addr < MODE_ADDR;
  assign is_ctrl  = in_slots && !reg_addr[0];
  assign is_res   = in_slots &&  reg_addr[0];
  assign a_grp    = GW'(reg_addr >> 1);

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_slot
      logic wr_me, rd_me;
      assign wr_me = reg_wr && is_ctrl && (a_grp == GW'(g));
      assign rd_me = reg_rd && is_res  && (a_grp == GW'(g));

      always_comb begin
        flag_d[g] = flag_q[g];
        if (rd_me) flag_d[g] = 1'b0;
        if (set_en && set_grp == GW'(g)) flag_d[g] = 1'b1;
        ie_d[g] = wr_me ? reg_wdata[CH_W+1] : slot_ie[g];
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          slot_chan[g] <= '0;
          slot_diff[g] <= 1'b0;
          slot_ie[g]   <= 1'b0;
          flag_q[g]    <= 1'b0;
        end else begin
          if (wr_me) begin
            slot_chan[g] <= reg_wdata[CH_W-1:0];
            slot_diff[g] <= reg_wdata[CH_W];
            slot_ie[g]   <= reg_wdata[CH_W+1];
          end
          flag_q[g] <= flag_d[g];
        end
      end

      // R6
      flag_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q[g]) |-> ($past(set_en) && $past(set_grp) == GW'(g)));

      // R9
      rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_me && !(set_en && set_grp == GW'(g))) |=> !flag_q[g]);
    end
  endgenerate

  // result storage: single write port, registered read
  always_ff @(posedge clk) begin
    if (set_en) res_mem[set_grp] <= ana_sample;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hw_en     <= 1'b0;
      cont      <= 1'b0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr == MODE_ADDR) begin
        hw_en <= reg_wdata[MODE_HW_BIT];
        cont  <= reg_wdata[MODE_CONT_BIT];
      end
      irq <= |(flag_d & ie_d);
      if (reg_rd) begin
        reg_rdata <= '0;
        if (is_ctrl)
          reg_rdata <= DATA_W'({flag_q[a_grp], slot_ie[a_grp], slot_diff[a_grp], slot_chan[a_grp]});
        else if (is_res)
          reg_rdata <= DATA_W'(res_mem[a_grp]);
        else if (reg_addr == MODE_ADDR) begin
          reg_rdata[MODE_HW_BIT]   <= hw_en;
          reg_rdata[MODE_CONT_BIT] <= cont;
        end else if (reg_addr == STAT_ADDR)
          reg_rdata <= DATA_W'({act_grp, busy});
      end
    end
  end

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|(flag_q & ie_d) || |$past(flag_d)));
endmodule

// File: rtl/adc_grp_sequencer.sv
module adc_grp_sequencer #(
  parameter int NUM_GRP  = 4,
  parameter int CH_W     = 5,
  parameter int RES_W    = 12,
  parameter int DATA_W   = 16,
  parameter int CONV_CYC = 6,
  parameter int AW       = $clog2(2 * NUM_GRP + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              hw_trig,
  input  logic [RES_W-1:0]  ana_sample,
  output logic [CH_W-1:0]   conv_chan,
  output logic              conv_diff,
  output logic              conv_busy,
  output logic              irq
);
  localparam int GW = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

  logic              hw_en, cont;
  logic              wr_ctrl, wr_mode;
  logic [GW-1:0]     wr_grp;
  logic              start, abort, fin, done, busy;
  logic [GW-1:0]     start_grp, act_grp;
  logic [CH_W-1:0]   slot_chan [NUM_GRP];
  logic              slot_diff [NUM_GRP];
  logic [CH_W-1:0]   start_chan;
  logic              start_diff;

  assign wr_ctrl = reg_wr && (reg_addr < AW'(2 * NUM_GRP)) && !reg_addr[0];
  assign wr_mode = reg_wr && (reg_addr == AW'(2 * NUM_GRP));
  assign wr_grp  = GW'(reg_addr >> 1);

  // settings written in the same edge as the start take effect at once
  always_comb begin
    if (wr_ctrl && wr_grp == start_grp) begin
      start_chan = reg_wdata[CH_W-1:0];
      start_diff = reg_wdata[CH_W];
    end else begin
      start_chan = slot_chan[start_grp];
      start_diff = slot_diff[start_grp];
    end
  end

  adc_grp_bank #(
    .NUM_GRP(NUM_GRP), .CH_W(CH_W), .RES_W(RES_W),
    .DATA_W(DATA_W), .AW(AW), .GW(GW)
  ) u_bank (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .set_en(fin), .set_grp(act_grp), .ana_sample(ana_sample),
    .busy(busy), .act_grp(act_grp),
    .reg_rdata(reg_rdata), .irq(irq), .hw_en(hw_en), .cont(cont),
    .slot_chan(slot_chan), .slot_diff(slot_diff)
  );

  adc_trig_sched #(.NUM_GRP(NUM_GRP), .GW(GW)) u_sched (
    .clk(clk), .rst(rst), .hw_en(hw_en), .cont(cont),
    .wr_ctrl(wr_ctrl), .wr_grp(wr_grp), .wr_mode(wr_mode), .hw_trig(hw_trig),
    .busy(busy), .done(done), .act_grp(act_grp),
    .start(start), .start_grp(start_grp), .abort(abort), .fin(fin)
  );

  adc_conv_stub #(.CONV_CYC(CONV_CYC), .CH_W(CH_W), .GW(GW)) u_conv (
    .clk(clk), .rst(rst), .start(start), .abort(abort),
    .start_grp(start_grp), .start_chan(start_chan), .start_diff(start_diff),
    .busy(busy), .done(done), .act_grp(act_grp),
    .conv_chan(conv_chan), .conv_diff(conv_diff)
  );

  assign conv_busy = busy;

  // R7
  other_wr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && wr_ctrl && wr_grp != act_grp && !start) |=> busy);
endmodule

// File: tb/sim_adc_grp_sequencer.sv
module sim_adc_grp_sequencer;
  localparam int PER  = 10;
  localparam int NG   = 4;
  localparam int CHW  = 5;
  localparam int RW   = 12;
  localparam int DW   = 16;
  localparam int CC   = 6;
  localparam int AW   = 4;
  localparam int FLAG = CHW + 2;
  localparam int IEB  = CHW + 1;
  localparam int DIFB = CHW;

  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_rd = 0, hw_trig = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [RW-1:0] ana_sample = '0;
  logic [CHW-1:0] conv_chan;
  logic conv_diff, conv_busy, irq;

  int n_chk = 0, n_fail = 0;

  always #(PER/2) clk = ~clk;

  adc_grp_sequencer #(.NUM_GRP(NG), .CH_W(CHW), .RES_W(RW), .DATA_W(DW), .CONV_CYC(CC)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_trig(hw_trig),
    .ana_sample(ana_sample), .conv_chan(conv_chan), .conv_diff(conv_diff),
    .conv_busy(conv_busy), .irq(irq)
  );

  function automatic logic [AW-1:0] a_ctrl(int g); return AW'(2*g);   endfunction
  function automatic logic [AW-1:0] a_res(int g);  return AW'(2*g+1); endfunction
  localparam logic [AW-1:0] A_MODE = AW'(2*NG);
  localparam logic [AW-1:0] A_STAT = AW'(2*NG+1);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a negedge and span one posedge
  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    reg_rd = 1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd = 0; d = reg_rdata;
  endtask

  task automatic trig();
    hw_trig = 1;
    @(posedge clk); @(negedge clk);
    hw_trig = 0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] cw(int ch, bit diff, bit ie);
    return DW'(ch) | (DW'(diff) << DIFB) | (DW'(ie) << IEB);
  endfunction

  task automatic t_reset();
    logic [DW-1:0] d;
    chk("R1 busy", conv_busy, 0);
    chk("R1 irq", irq, 0);
    rd(A_STAT, d);    chk("R1 status", d, 0);
    rd(a_ctrl(0), d); chk("R1 ctrl0", d, 0);
    rd(A_MODE, d);    chk("R1 mode", d, 0);
  endtask

  task automatic t_sw_conv();
    logic [DW-1:0] d;
    ana_sample = 12'h234;
    wr(a_ctrl(0), cw(5, 0, 1));
    chk("R2 busy after start", conv_busy, 1);
    chk("R12 chan", conv_chan, 5);
    wait_cyc(CC-1);
    chk("R2 busy last cycle", conv_busy, 1);
    wait_cyc(1);
    chk("R2 busy end", conv_busy, 0);
    chk("R8 irq set", irq, 1);
    rd(a_ctrl(0), d); chk("R2 flag", d[FLAG], 1);
    rd(a_res(0), d);  chk("R2 result", d, 16'h0234);
    rd(a_ctrl(0), d); chk("R9 flag cleared", d[FLAG], 0);
    chk("R8 irq clear", irq, 0);
  endtask

  task automatic t_sw_other();
    wr(a_ctrl(1), cw(9, 0, 0));
    wait_cyc(2);
    chk("R3 sw slot1 no start", conv_busy, 0);
  endtask

  task automatic t_sw_restart();
    wr(a_ctrl(0), cw(7, 0, 0));
    wait_cyc(2);
    wr(a_ctrl(0), cw(8, 1, 0));
    chk("R6 restart chan", conv_chan, 8);
    chk("R12 diff", conv_diff, 1);
    wait_cyc(CC-1);
    chk("R6 restart timing busy", conv_busy, 1);
    wait_cyc(1);
    chk("R6 restart done", conv_busy, 0);
  endtask

  task automatic t_hw_abort_disturb();
    logic [DW-1:0] d;
    wr(A_MODE, 16'h1);
    wr(a_ctrl(0), cw(3, 0, 0));
    wait_cyc(1);
    chk("R3 hw ctrl write no start", conv_busy, 0);
    rd(a_res(0), d); // clear slot 0 flag from earlier run
    trig();
    chk("R4 first trig busy", conv_busy, 1);
    chk("R4 first trig chan", conv_chan, 3);
    rd(A_STAT, d); chk("R11 status g0", d, 16'h1);
    wr(a_ctrl(0), cw(4, 0, 0));
    chk("R6 abort busy", conv_busy, 0);
    wait_cyc(CC+1);
    rd(a_ctrl(0), d); chk("R6 abort no flag", d[FLAG], 0);
    wr(a_ctrl(1), cw(11, 0, 0));
    trig();                              // P0: slot 1
    wr(a_ctrl(2), cw(12, 0, 0));         // P1
    chk("R7 busy kept", conv_busy, 1);
    trig();                              // P2: ignored
    rd(A_STAT, d);                       // P3
    chk("R5 status still g1", d, 16'h3);
    chk("R7 chan kept", conv_chan, 11);
    wait_cyc(CC-4);
    chk("R7 timing busy", conv_busy, 1);
    wait_cyc(1);
    chk("R7 timing done", conv_busy, 0);
    rd(a_ctrl(1), d); chk("R7 slot1 flag", d[FLAG], 1);
    rd(a_ctrl(2), d); chk("R7 slot2 no flag", d[FLAG], 0);
    chk("R8 no irq without enable", irq, 0);
    rd(a_res(1), d);
  endtask

  task automatic t_rotation();
    logic [DW-1:0] d;
    wr(a_ctrl(3), cw(13, 0, 0));
    wr(a_ctrl(0), cw(10, 0, 0));
    // pointer is at 2 (slot 1 used, ignored trigger did not advance)
    for (int k = 0; k < 5; k++) begin
      int eg;
      eg = (2 + k) % NG;
      trig();
      chk("R4 rotation chan", conv_chan, 10 + eg);
      wait_cyc(CC);
      rd(a_ctrl(eg), d);
      chk("R4 rotation flag", d[FLAG], 1);
    end
    rd(a_res(3), d);
    rd(a_ctrl(3), d); chk("R9 own flag cleared", d[FLAG], 0);
    rd(a_ctrl(2), d); chk("R9 other flag kept", d[FLAG], 1);
  endtask

  task automatic t_cont();
    logic [DW-1:0] d;
    wr(A_MODE, 16'h2);
    ana_sample = 12'h111;
    wr(a_ctrl(0), cw(1, 0, 0));          // P0
    wait_cyc(CC);                         // P0+CC
    chk("R10 restarted busy", conv_busy, 1);
    rd(a_res(0), d);                      // P0+CC+1
    chk("R10 first result", d, 16'h0111);
    ana_sample = 12'h222;
    wait_cyc(CC-1);                       // P0+2CC
    rd(a_res(0), d);
    chk("R10 second result", d, 16'h0222);
    wr(A_MODE, 16'h0);
    wait_cyc(CC+1);
    chk("R10 stops when off", conv_busy, 0);
  endtask

  initial begin
    #(PER*100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_sw_conv();
    t_sw_other();
    t_sw_restart();
    t_hw_abort_disturb();
    t_rotation();
    t_cont();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule